// File: doc/BRIEF.md
# Fixed-Latency Line Memory with Requester Lock

This block is a backing store organised as lines of four words. It sits below a cache and serves one requester at a time. A requester identifies itself with a small encoded ID and issues either a single-word write or a whole-line read. In every cycle the block answers with a status bit: WAIT (`resp_ok` low) or OK (`resp_ok` high).

The first requester with a valid ID to arrive while the block is free becomes the owner. A countdown, loaded with the `DELAY` parameter, then steps down once per cycle for as long as an owner exists. The owner's access happens in the cycle the countdown stands at zero. In that cycle the owner is released and the countdown reloads. Any other requester is told to wait and changes nothing. With `DELAY` set to zero, every request completes in the cycle it is issued.

A word address is split into a line index (the address divided by four) and a word slot (the address modulo four). A read returns all four words of the addressed line on the OK cycle only.

Top module: `lmem_line_memory`

## Requirements
- R1: After reset every stored word is zero, so the first read of any line returns an all-zero line.
- R2: A write to word address A stores the data in line A/4 at slot A%4, which is `req_addr[1:0]`. Slot k of a line appears on `resp_line[k*WORD_W +: WORD_W]`.
- R3: On a read that gets OK, `resp_line` carries all four words of the line holding `req_addr`. In every other cycle `resp_line` is all zeros.
- R4: ID value 0 means "no requester". A request with ID 0 always gets WAIT, never takes ownership and changes nothing.
- R5: While an owner holds the block, a request from any other nonzero ID gets WAIT and has no effect on storage.
- R6: Once a requester claims the free block, the countdown drops by one every cycle while an owner exists, whether or not the owner keeps requesting. The owner gets WAIT for `DELAY` cycles and OK on its request in the cycle the countdown is zero.
- R7: In the cycle the countdown is zero, ownership is released and the countdown reloads to `DELAY`. An owner that does not request in that cycle loses its slot without any access, and another requester may claim in the next cycle.
- R8: With `DELAY` = 0, a request from a nonzero ID gets OK in the same cycle it is issued.
- R9: Storage changes only in a write's OK cycle. A write repeated during WAIT with different data leaves only the data presented in the OK cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_id | input | ID_W | Requester ID; 0 is reserved for "none" |
| req_write | input | 1 | 1 = word write, 0 = line read |
| req_addr | input | ADDR_W | Word address (line = addr/4, slot = addr%4) |
| req_wdata | input | WORD_W | Word to store on a write |
| resp_ok | output | 1 | 1 = OK (access done this cycle), 0 = WAIT |
| resp_line | output | 4*WORD_W | Line read out on an OK read, else zero |

## Verification
The assertions assume that the request fields hold steady within a cycle and that a requester that receives WAIT will repeat its request. They also assume that `DELAY` fits the counter width derived from it. The bench drives every input once per clock, a fixed time after the rising edge, and keeps it there until the next edge. It repeats owner requests until OK and uses ID 0 only to test that the reserved value is inert. A second instance with zero delay receives its own short sequence, so the two instances' timing never mixes.

// File: rtl/lmem_pkg.sv
`timescale 1ns/1ps
package lmem_pkg;
  localparam int unsigned SLOTS  = 4;
  localparam int unsigned SLOT_W = 2;

  // line that holds a word address
  function automatic logic [31:0] line_of(input logic [31:0] waddr);
    return waddr / SLOTS;
  endfunction

  // slot of a word address within its line
  function automatic logic [31:0] slot_of(input logic [31:0] waddr);
    return waddr % SLOTS;
  endfunction

  // width of a down-counter able to hold value v (at least 1)
  function automatic int unsigned cnt_width(input int unsigned v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/lmem_owner_lock.sv
`timescale 1ns/1ps
module lmem_owner_lock #(
  parameter int unsigned ID_W  = 2,
  parameter int unsigned DELAY = 3,
  parameter int unsigned CNT_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  output logic            grant_ok
);
  localparam logic [ID_W-1:0]  NONE_ID = '0;
  localparam logic [CNT_W-1:0] RELOAD  = CNT_W'(DELAY);

  logic [ID_W-1:0]  owner_q;
  logic [ID_W-1:0]  owner_eff;
  logic [CNT_W-1:0] cnt_q;
  logic             live_req;
  logic             is_owner_req;
  logic             cnt_zero;
  logic             slot_busy;

  assign live_req     = req_valid && (req_id != NONE_ID);
  assign owner_eff    = (owner_q == NONE_ID && live_req) ? req_id : owner_q;
  assign is_owner_req = live_req && (owner_eff == req_id);
  assign cnt_zero     = (cnt_q == '0);
  assign slot_busy    = (owner_eff != NONE_ID);
  assign grant_ok     = is_owner_req && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= NONE_ID;
      cnt_q   <= RELOAD;
    end else if (slot_busy) begin
      if (cnt_zero) begin
        owner_q <= NONE_ID;
        cnt_q   <= RELOAD;
      end else begin
        owner_q <= owner_eff;
        cnt_q   <= cnt_q - 1'b1;
      end
    end
  end

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != NONE_ID && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != NONE_ID && cnt_q != '0) |=> (owner_q == $past(owner_q)));

  // R5
  foreign_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && owner_q != NONE_ID && req_id != owner_q) |-> !grant_ok);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != NONE_ID && cnt_q == '0) |=> (owner_q == NONE_ID && cnt_q == RELOAD));

  // R4
  none_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_id == NONE_ID) |-> !grant_ok);

  // R4
  no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == NONE_ID && !(req_valid && req_id != NONE_ID)) |=> (owner_q == NONE_ID));
endmodule

// File: rtl/lmem_line_store.sv
`timescale 1ns/1ps
module lmem_line_store #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned LINE_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [LINE_W-1:0]              line_idx,
  input  logic [lmem_pkg::SLOT_W-1:0]    slot_idx,
  input  logic [WORD_W-1:0]              wdata,
  output logic [lmem_pkg::SLOTS*WORD_W-1:0] line_out
);
  import lmem_pkg::*;

  logic [NUM_LINES-1:0][SLOTS-1:0][WORD_W-1:0] mem_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem_q[g][s] <= '0;
        else if (wr_en && line_idx == LINE_W'(g) && slot_idx == SLOT_W'(s))
          mem_q[g][s] <= wdata;
      end
    end
  end

  assign line_out = mem_q[line_idx];

  // R2
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(line_idx)][$past(slot_idx)] == $past(wdata)));

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/lmem_line_memory.sv
`timescale 1ns/1ps
module lmem_line_memory #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ID_W      = 2,
  parameter int unsigned DELAY     = 3,
  parameter int unsigned LINE_W    = $clog2(NUM_LINES),
  parameter int unsigned ADDR_W    = LINE_W + lmem_pkg::SLOT_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic [ID_W-1:0]                   req_id,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [WORD_W-1:0]                 req_wdata,
  output logic                              resp_ok,
  output logic [lmem_pkg::SLOTS*WORD_W-1:0] resp_line
);
  import lmem_pkg::*;

  localparam int unsigned CNT_W = cnt_width(DELAY);

  logic                      grant_ok;
  logic                      wr_fire;
  logic                      rd_fire;
  logic [LINE_W-1:0]         line_idx;
  logic [SLOT_W-1:0]         slot_idx;
  logic [SLOTS*WORD_W-1:0]   line_raw;

  assign line_idx = LINE_W'(line_of(32'(req_addr)));
  assign slot_idx = SLOT_W'(slot_of(32'(req_addr)));
  assign wr_fire  = grant_ok && req_write;
  assign rd_fire  = grant_ok && !req_write;

  lmem_owner_lock #(
    .ID_W (ID_W),
    .DELAY(DELAY),
    .CNT_W(CNT_W)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_id   (req_id),
    .grant_ok (grant_ok)
  );

  lmem_line_store #(
    .WORD_W   (WORD_W),
    .NUM_LINES(NUM_LINES),
    .LINE_W   (LINE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .line_idx(line_idx),
    .slot_idx(slot_idx),
    .wdata   (req_wdata),
    .line_out(line_raw)
  );

  assign resp_ok   = grant_ok;
  assign resp_line = rd_fire ? line_raw : '0;

  // R3
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_ok || req_write) |-> (resp_line == '0));
endmodule

// File: tb/lmem_line_memory_tb_top.sv
`timescale 1ns/1ps
module lmem_line_memory_tb_top;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_LINES = 16;
  localparam int unsigned ID_W      = 2;
  localparam int unsigned DELAY     = 3;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned LW        = 4 * WORD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [ID_W-1:0]   req_id = '0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic              resp_ok;
  logic [LW-1:0]     resp_line;

  logic              z_valid = 1'b0;
  logic [ID_W-1:0]   z_id = '0;
  logic              z_write = 1'b0;
  logic [ADDR_W-1:0] z_addr = '0;
  logic [WORD_W-1:0] z_wdata = '0;
  logic              z_ok;
  logic [LW-1:0]     z_line;

  lmem_line_memory #(.WORD_W(WORD_W), .NUM_LINES(NUM_LINES), .ID_W(ID_W), .DELAY(DELAY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_ok(resp_ok), .resp_line(resp_line));

  lmem_line_memory #(.WORD_W(WORD_W), .NUM_LINES(NUM_LINES), .ID_W(ID_W), .DELAY(0)) dut_z (
    .clk(clk), .rst_n(rst_n), .req_valid(z_valid), .req_id(z_id), .req_write(z_write),
    .req_addr(z_addr), .req_wdata(z_wdata), .resp_ok(z_ok), .resp_line(z_line));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // scoreboard queues
  bit            q_ok[$];
  logic [LW-1:0] q_line[$];
  string         q_tag[$];

  // reference state
  logic [WORD_W-1:0] m_mem [NUM_LINES*4];
  logic [ID_W-1:0]   m_owner;
  int                m_cnt;

  task automatic step(input bit v, input logic [ID_W-1:0] id, input bit wr,
                      input int addr, input logic [WORD_W-1:0] data, input string tag);
    bit claim;
    bit ok;
    logic [ID_W-1:0] eown;
    logic [LW-1:0] exp_line;
    eown  = (m_owner == 0 && v && id != 0) ? id : m_owner;
    claim = v && id != 0 && eown == id;
    ok    = claim && m_cnt == 0;
    exp_line = '0;
    if (ok && !wr)
      for (int k = 0; k < 4; k++) exp_line[k*WORD_W +: WORD_W] = m_mem[(addr / 4) * 4 + k];
    req_valid = v; req_id = id; req_write = wr; req_addr = ADDR_W'(addr); req_wdata = data;
    q_ok.push_back(ok); q_line.push_back(exp_line); q_tag.push_back(tag);
    @(posedge clk);
    if (ok && wr) m_mem[addr] = data;
    if (eown != 0) begin
      if (m_cnt == 0) begin m_owner = 0; m_cnt = DELAY; end
      else begin m_owner = eown; m_cnt = m_cnt - 1; end
    end
    #1;
  endtask

  // repeat a request until the reference says OK (bounded)
  task automatic until_ok(input logic [ID_W-1:0] id, input bit wr, input int addr,
                          input logic [WORD_W-1:0] data, input string tag);
    for (int n = 0; n < DELAY + 2; n++) begin
      bit last;
      last = (m_owner == id || m_owner == 0) && m_cnt == 0;
      step(1'b1, id, wr, addr, data, tag);
      if (last) break;
    end
  endtask

  // monitor: compare outputs with expectations away from the clock edge
  always @(negedge clk) begin
    if (q_ok.size() > 0) begin
      bit eo;
      logic [LW-1:0] el;
      string t;
      eo = q_ok.pop_front(); el = q_line.pop_front(); t = q_tag.pop_front();
      total++;
      if (resp_ok !== eo || resp_line !== el) begin
        bad++;
        $display("FAIL %s: ok=%0b line=%h expected ok=%0b line=%h", t, resp_ok, resp_line, eo, el);
      end
    end
  end

  task automatic chk_z(input bit eo, input logic [LW-1:0] el, input string t);
    total++;
    if (z_ok !== eo || z_line !== el) begin
      bad++;
      $display("FAIL %s: ok=%0b line=%h expected ok=%0b line=%h", t, z_ok, z_line, eo, el);
    end
  endtask

  initial begin
    for (int i = 0; i < NUM_LINES * 4; i++) m_mem[i] = '0;
    m_owner = 0; m_cnt = DELAY;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R3: quiet port after reset, then first read of a line is all zero
    step(1'b0, 2'd0, 1'b0, 0, 0, "R1 idle after reset");
    until_ok(2'd1, 1'b0, 9, 0, "R1 R6 first read of line 2");

    // R4: ID 0 neither claims nor acts
    step(1'b1, 2'd0, 1'b1, 5, 32'hDEAD0000, "R4 none-id write");
    step(1'b1, 2'd0, 1'b0, 5, 0, "R4 none-id read");

    // R5 / R6: id2 claims, id1 interleaves and is refused
    step(1'b1, 2'd2, 1'b1, 6, 32'hAAAA0006, "R6 claim by id2");
    step(1'b1, 2'd1, 1'b1, 13, 32'hBBBB000D, "R5 foreign write while owned");
    until_ok(2'd2, 1'b1, 6, 32'hAAAA0006, "R6 owner write completes");

    // R9: changing data during WAIT, only OK-cycle data lands
    for (int n = 0; n < DELAY; n++) step(1'b1, 2'd3, 1'b1, 7, 32'h1111_0000 + n, "R9 write during wait");
    step(1'b1, 2'd3, 1'b1, 7, 32'h7777_0007, "R9 write on OK cycle");

    // R2 / R3: line 1 holds slots 2 and 3; line 3 untouched by refused write
    until_ok(2'd1, 1'b0, 4, 0, "R2 R3 read line 1");
    until_ok(2'd1, 1'b0, 13, 0, "R5 refused write left line 3 zero");

    // R7: owner abandons its slot, then another claims
    step(1'b1, 2'd1, 1'b1, 20, 32'hCCCC0014, "R7 claim then leave");
    for (int n = 0; n < DELAY; n++) step(1'b0, 2'd0, 1'b0, 0, 0, "R7 countdown without requests");
    until_ok(2'd2, 1'b0, 20, 0, "R7 new owner sees no write from lost slot");

    // R2: fill all four slots of line 10 then read back
    for (int k = 0; k < 4; k++) until_ok(2'd3, 1'b1, 40 + k, 32'h5000_0000 + k, "R2 fill line 10");
    until_ok(2'd2, 1'b0, 42, 0, "R2 R3 full line 10 read");

    // R3: read of last line boundary
    until_ok(2'd1, 1'b1, 63, 32'hFFFF_003F, "R2 last word write");
    until_ok(2'd1, 1'b0, 60, 0, "R3 last line read");
    step(1'b0, 2'd0, 1'b0, 0, 0, "R3 quiet after read");

    // R8: zero-delay instance completes in the issue cycle
    z_valid = 1'b1; z_id = 2'd2; z_write = 1'b1; z_addr = 6'd5; z_wdata = 32'h0ABC_0005;
    @(negedge clk); chk_z(1'b1, '0, "R8 zero-delay write OK");
    @(posedge clk); #1;
    z_id = 2'd3; z_write = 1'b0; z_addr = 6'd4;
    @(negedge clk); chk_z(1'b1, {32'h0, 32'h0, 32'h0ABC_0005, 32'h0}, "R8 zero-delay read OK");
    @(posedge clk); #1;
    z_id = 2'd0;
    @(negedge clk); chk_z(1'b0, '0, "R4 R8 none-id on zero-delay");
    @(posedge clk); #1;
    z_valid = 1'b0;

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule